// File: doc/BRIEF.md
# Buffered Return-to-Zero Word Transmitter

This block serialises 32-bit words onto a pair of return-to-zero rails for an avionics-style simplex data bus. A host writes words into an eight-deep buffer while the transmitter is disabled. Each word is written as two 16-bit halves: a first-half strobe stages the low half, and a second-half strobe supplies the high half and commits the word. When the enable input is raised, the block sends every buffered word in load order. The host takes no further part.

Each word goes out least significant bit first, as 32 bits or as 25 bits. The final bit carries either a parity bit or the loaded data bit. A minimum of four null bit times separates consecutive words. A free-running bit clock, high during the first half of every bit time, is brought out alongside the rails. A ready flag reports an empty buffer. The host provides the option bits directly: word length, rate, parity sense, parity enable and a parity-force input.

Top module: `rz_word_tx`

## Requirements
- R1: A `load_lo_i` pulse stages `data_i` as bits 15:0. A following `load_hi_i` pulse commits {`data_i`, staged half} as one word at the buffer tail. A `load_hi_i` pulse with no half staged since the last commit is dropped.
- R2: Both load strobes are ignored while `tx_en_i` is high. Buffered words are sent in load order, and a word only starts while `tx_en_i` is high.
- R3: When the buffer already holds DEPTH words, a further committed load replaces the newest entry and does not add a new one.
- R4: `ready_o` is 1 after reset and falls one cycle after a committed load. It rises at the end of the final bit time of the last buffered word.
- R5: Word bit 0 is sent first. When `short_word_i`=0 a word is 32 bits (bits 0..31). When `short_word_i`=1 it is 25 bits (bits 0..24), and bit 24 is the final bit.
- R6: A bit time is HI_DIV clock cycles when `slow_rate_i`=0 and LO_DIV cycles when it is 1. For a 1, `rail_a_o` is high during the first half of the bit time. For a 0, `rail_b_o` is high during the first half. Both rails are low during the second half and during null bits, and they are never high together.
- R7: `bit_clk_o` runs continuously with a 50% duty cycle. It is high during the first half of every bit time, so it is high whenever a rail is high.
- R8: Consecutive word starts are at least (length+4) bit times apart, and exactly that far apart when words are sent back to back. The gap also applies to a block enabled straight after `ready_o` rises, and to the first word after reset.
- R9: The final bit is a parity bit if `par_force_i`=1 or `par_en_i`=1. The parity bit makes the count of ones in the whole word odd when `par_even_i`=0, or even when `par_even_i`=1. Otherwise the final bit is the loaded data bit at that position.
- R10: Word length and rate are taken from the inputs only while `ready_o` is high. A change made while a word is in flight does not affect that word.
- R11: An active-low `rst_ni` forces both rails low, empties the buffer so that nothing is sent after reset is released, clears the gap timer and sets `ready_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| data_i | input | 16 | Load data half |
| load_lo_i | input | 1 | Stage low half (one-cycle pulse) |
| load_hi_i | input | 1 | Supply high half and commit word (one-cycle pulse) |
| tx_en_i | input | 1 | Transmit enable; loads ignored while high |
| short_word_i | input | 1 | 1 = 25-bit words, 0 = 32-bit words |
| slow_rate_i | input | 1 | 1 = LO_DIV cycles per bit, 0 = HI_DIV |
| par_even_i | input | 1 | Parity sense: 1 = even, 0 = odd |
| par_en_i | input | 1 | Parity insertion when the parity-force input is low |
| par_force_i | input | 1 | 1 = always insert parity in the final bit |
| rail_a_o | output | 1 | RZ rail for one bits |
| rail_b_o | output | 1 | RZ rail for zero bits |
| bit_clk_o | output | 1 | Free-running bit clock |
| ready_o | output | 1 | Buffer empty |

## Verification
A committed load lowers `ready_o` on the next edge, so the bench checks it at the falling edge that follows the strobe. A bit that begins at a boundary raises its rail in the first cycle of the bit time. The bench stamps each rail rise with the cycle counter and checks that successive bits are exactly one bit time apart. It also checks that word starts are exactly (length+4) bit times apart when words go back to back. `ready_o` rises on the edge that ends the final bit, so word contents are compared only after that rise plus a few cycles. Each word is rebuilt from the rail that was high at each rise.

// File: rtl/rz_tx_pkg.sv
package rz_tx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/rz_tx_fifo.sv
module rz_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             last_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_prev;
  logic [CNT_W-1:0] count_q;
  logic             full, overwrite;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (count_q == CNT_W'(DEPTH));
  assign overwrite = push_i && full && !pop_i;   // replace newest entry
  assign wr_prev   = (wr_q == '0) ? PTR_MAX : wr_q - PTR_W'(1);
  assign rdata_o   = mem_q[rd_q];
  assign empty_o   = (count_q == '0);
  assign last_o    = (count_q == CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[overwrite ? wr_prev : wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i && !overwrite) wr_q <= ptr_inc(wr_q);
      if (pop_i) rd_q <= ptr_inc(rd_q);
      case ({push_i && !overwrite, pop_i})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0); // R2
endmodule

// File: rtl/rz_tx_timebase.sv
module rz_tx_timebase #(
  parameter int HI_DIV = 10,
  parameter int LO_DIV = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_rate_i,
  output logic tick_o,
  output logic first_half_o
);
  localparam int MAX_DIV = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q, div_m1, half;

  assign div_m1       = slow_rate_i ? CNT_W'(LO_DIV - 1) : CNT_W'(HI_DIV - 1);
  assign half         = slow_rate_i ? CNT_W'(LO_DIV / 2) : CNT_W'(HI_DIV / 2);
  assign tick_o       = (cnt_q >= div_m1);     // last cycle of a bit time
  assign first_half_o = (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rz_tx_serializer.sv
module rz_tx_serializer
  import rz_tx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SHORT_LEN = 25,
  parameter int GAP_BITS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              first_half_i,
  input  logic              tx_en_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              short_word_i,
  input  logic              par_en_i,
  input  logic              par_force_i,
  input  logic              par_even_i,
  output logic              pop_o,
  output logic              rail_a_o,
  output logic              rail_b_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int GAP_W = $clog2(GAP_BITS + 1);
  localparam logic [IDX_W-1:0] LONG_M1  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] SHORT_M1 = IDX_W'(SHORT_LEN - 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_BITS);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q, len_m1;
  logic [GAP_W-1:0]  gap_q;
  logic [WORD_W-1:0] sh_q, data_mask, composed;
  logic              par, fin_bit, start, last;

  always_comb begin
    len_m1    = short_word_i ? SHORT_M1 : LONG_M1;
    data_mask = (WORD_W'(1) << len_m1) - WORD_W'(1);
    par       = ^(word_i & data_mask);
    fin_bit   = (par_force_i || par_en_i) ? (par_even_i ? par : ~par) : word_i[len_m1];
    composed  = (word_i & data_mask) | (WORD_W'(fin_bit) << len_m1);
  end

  // a word may start only once the last null bit of the gap ends
  assign start    = tick_i && (state_q == TX_IDLE) && (gap_q >= GAP_LAST) && tx_en_i && avail_i;
  assign last     = (state_q == TX_SEND) && (idx_q == len_m1);
  assign pop_o    = tick_i && last;
  assign rail_a_o = (state_q == TX_SEND) && first_half_i && sh_q[0];
  assign rail_b_o = (state_q == TX_SEND) && first_half_i && !sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      sh_q    <= '0;
    end else if (tick_i) begin
      if (state_q == TX_IDLE) begin
        if (gap_q != GAP_FULL) gap_q <= gap_q + GAP_W'(1);
        if (start) begin
          state_q <= TX_SEND;
          idx_q   <= '0;
          sh_q    <= composed;
        end
      end else if (last) begin
        state_q <= TX_IDLE;
        gap_q   <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        sh_q  <= sh_q >> 1;
      end
    end
  end

  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SEND && $past(state_q == TX_SEND)) |-> $stable(short_word_i)); // R10
endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx
  import rz_tx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HI_DIV    = 10,
  parameter int LO_DIV    = 80,
  parameter int GAP_BITS  = 4,
  parameter int SHORT_LEN = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic              tx_en_i,
  input  logic              short_word_i,
  input  logic              slow_rate_i,
  input  logic              par_even_i,
  input  logic              par_en_i,
  input  logic              par_force_i,
  output logic              rail_a_o,
  output logic              rail_b_o,
  output logic              bit_clk_o,
  output logic              ready_o
);
  logic [HALF_W-1:0] lo_q;
  logic              lo_vld_q, ready_q, short_q, slow_q;
  logic              lo_cap, push, pop, empty, last_entry, tick, first_half;
  logic [WORD_W-1:0] head;

  assign lo_cap = load_lo_i && !tx_en_i;
  assign push   = load_hi_i && lo_vld_q && !tx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      lo_vld_q <= 1'b0;
      ready_q  <= 1'b1;
      short_q  <= 1'b0;
      slow_q   <= 1'b0;
    end else begin
      if (lo_cap) begin
        lo_q     <= data_i;
        lo_vld_q <= 1'b1;
      end else if (push) begin
        lo_vld_q <= 1'b0;
      end
      if (push)                    ready_q <= 1'b0;
      else if (pop && last_entry)  ready_q <= 1'b1;
      // line format follows the inputs only while nothing is queued
      if (ready_q) begin
        short_q <= short_word_i;
        slow_q  <= slow_rate_i;
      end
    end
  end

  rz_tx_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i ({data_i, lo_q}),
    .pop_i   (pop),
    .rdata_o (head),
    .empty_o (empty),
    .last_o  (last_entry)
  );

  rz_tx_timebase #(.HI_DIV(HI_DIV), .LO_DIV(LO_DIV)) u_timebase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slow_rate_i  (slow_q),
    .tick_o       (tick),
    .first_half_o (first_half)
  );

  rz_tx_serializer #(.WORD_W(WORD_W), .SHORT_LEN(SHORT_LEN), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .first_half_i (first_half),
    .tx_en_i      (tx_en_i),
    .avail_i      (!empty),
    .word_i       (head),
    .short_word_i (short_q),
    .par_en_i     (par_en_i),
    .par_force_i  (par_force_i),
    .par_even_i   (par_even_i),
    .pop_o        (pop),
    .rail_a_o     (rail_a_o),
    .rail_b_o     (rail_b_o)
  );

  assign bit_clk_o = first_half;
  assign ready_o   = ready_q;

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rail_a_o && rail_b_o)); // R6
  AST_RAIL_IN_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_a_o || rail_b_o) |-> bit_clk_o); // R7
  AST_READY_IS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q == empty); // R4
  AST_NO_LOAD_WHILE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_q) |-> !$past(tx_en_i)); // R2
endmodule

// File: tb/rz_word_tx_tb.sv
`timescale 1ns/1ps
module rz_word_tx_tb;
  localparam int HI_DIV = 10;
  localparam int LO_DIV = 80;
  // {par_even, par_force, par_en, slow, short, word}
  localparam int NV = 6;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_0001},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00A5_5A3C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0155_AAAA}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic load_lo_i = 0, load_hi_i = 0, tx_en_i = 0;
  logic short_word_i = 0, slow_rate_i = 0, par_even_i = 0, par_en_i = 0, par_force_i = 0;
  logic rail_a_o, rail_b_o, bit_clk_o, ready_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_cnt = 0;
  logic rx_bit [1024];
  logic rx_clk [1024];
  int   rx_cyc [1024];
  logic prev_on = 1'b0;

  always #2.5 clk = ~clk;

  rz_word_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .load_lo_i(load_lo_i),
    .load_hi_i(load_hi_i), .tx_en_i(tx_en_i), .short_word_i(short_word_i),
    .slow_rate_i(slow_rate_i), .par_even_i(par_even_i), .par_en_i(par_en_i),
    .par_force_i(par_force_i), .rail_a_o(rail_a_o), .rail_b_o(rail_b_o),
    .bit_clk_o(bit_clk_o), .ready_o(ready_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && (rail_a_o || rail_b_o) && !prev_on && rx_cnt < 1024) begin
      rx_bit[rx_cnt] = rail_a_o;
      rx_clk[rx_cnt] = bit_clk_o;
      rx_cyc[rx_cnt] = cyc;
      rx_cnt++;
    end
    prev_on = rail_a_o || rail_b_o;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic short_w,
                                           input logic pen, input logic pforce, input logic peven);
    int len = short_w ? 25 : 32;
    logic [31:0] m = (32'd1 << (len - 1)) - 32'd1;
    logic p = ^(w & m);
    logic f = (pen || pforce) ? (peven ? p : ~p) : w[len-1];
    return (w & m) | (32'(f) << (len - 1));
  endfunction

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); data_i = w[15:0];  load_lo_i = 1;
    @(negedge clk); load_lo_i = 0; data_i = w[31:16]; load_hi_i = 1;
    @(negedge clk); load_hi_i = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 40000 && !ready_o; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] got_word(input int base, input int len);
    logic [31:0] g = '0;
    for (int k = 0; k < len; k++) g[k] = rx_bit[base + k];
    return g;
  endfunction

  task automatic check_word(input int base, input int len, input int div,
                            input logic [31:0] exp, input string tag);
    logic sp_ok = 1'b1, ck_ok = 1'b1;
    chk(got_word(base, len) == exp, tag, got_word(base, len), exp);
    for (int k = 0; k < len - 1; k++)
      if (rx_cyc[base + k + 1] - rx_cyc[base + k] != div) sp_ok = 1'b0;
    chk(sp_ok, "R6 bit spacing", 32'(rx_cyc[base + 1] - rx_cyc[base]), 32'(div));
    for (int k = 0; k < len; k++) if (!rx_clk[base + k]) ck_ok = 1'b0;
    chk(ck_ok, "R7 clk high at rail rise", 32'(ck_ok), 32'd1);
  endtask

  task automatic run_vec(input logic [36:0] v);
    int base, len, div;
    logic [31:0] exp;
    tx_en_i = 0;
    {par_even_i, par_force_i, par_en_i, slow_rate_i, short_word_i} = v[36:32];
    len = v[32] ? 25 : 32;
    div = v[33] ? LO_DIV : HI_DIV;
    exp = exp_word(v[31:0], v[32], v[34], v[35], v[36]);
    repeat (3) @(negedge clk);
    base = rx_cnt;
    load_word(v[31:0]);
    chk(ready_o == 1'b0, "R4 ready falls on load", 32'(ready_o), 32'd0);
    tx_en_i = 1;
    wait_ready();
    repeat (4) @(negedge clk);
    chk(rx_cnt - base == len, "R5 bit count", 32'(rx_cnt - base), 32'(len));
    check_word(base, len, div, exp, "R9 R5 word contents");
    tx_en_i = 0;
  endtask

  initial begin
    int base, hi_cnt;
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R4 ready at reset", 32'(ready_o), 32'd1);
    chk(!rail_a_o && !rail_b_o, "R6 rails low at reset", {30'd0, rail_a_o, rail_b_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk);

    // R7: duty cycle at the fast rate
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (bit_clk_o) hi_cnt++; end
    chk(hi_cnt == 20, "R7 duty fast", 32'(hi_cnt), 32'd20);

    // vector table
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7: duty cycle at the slow rate
    slow_rate_i = 1;
    repeat (100) @(negedge clk);
    hi_cnt = 0;
    for (int i = 0; i < 160; i++) begin @(negedge clk); if (bit_clk_o) hi_cnt++; end
    chk(hi_cnt == 80, "R7 duty slow", 32'(hi_cnt), 32'd80);
    slow_rate_i = 0; short_word_i = 0; par_en_i = 0; par_force_i = 1; par_even_i = 0;
    repeat (100) @(negedge clk);

    // R1: second half with nothing staged is dropped
    @(negedge clk); data_i = 16'hBEEF; load_hi_i = 1;
    @(negedge clk); load_hi_i = 0;
    @(negedge clk);
    chk(ready_o == 1'b1, "R1 unpaired high half dropped", 32'(ready_o), 32'd1);

    // R8 R2: back-to-back block keeps order and exact slot
    base = rx_cnt;
    load_word(32'h0000_0011); load_word(32'h0000_0022); load_word(32'h0000_0033);
    tx_en_i = 1;
    wait_ready();
    tx_en_i = 0;
    load_word(32'h0000_0044);
    tx_en_i = 1;
    wait_ready();
    repeat (4) @(negedge clk);
    chk(rx_cnt - base == 128, "R2 block bit count", 32'(rx_cnt - base), 32'd128);
    chk(got_word(base + 32, 32) == exp_word(32'h22, 0, 0, 1, 0), "R2 order word2",
        got_word(base + 32, 32), exp_word(32'h22, 0, 0, 1, 0));
    chk(got_word(base + 64, 32) == exp_word(32'h33, 0, 0, 1, 0), "R2 order word3",
        got_word(base + 64, 32), exp_word(32'h33, 0, 0, 1, 0));
    chk(rx_cyc[base + 32] - rx_cyc[base] == 360, "R8 back-to-back slot",
        32'(rx_cyc[base + 32] - rx_cyc[base]), 32'd360);
    chk(rx_cyc[base + 96] - rx_cyc[base + 64] == 360, "R8 gap after re-enable",
        32'(rx_cyc[base + 96] - rx_cyc[base + 64]), 32'd360);

    // R2: loads ignored while enabled
    base = rx_cnt;
    load_word(32'hDEAD_BEEF);
    chk(ready_o == 1'b1, "R2 load ignored while enabled", 32'(ready_o), 32'd1);
    repeat (600) @(negedge clk);
    chk(rx_cnt == base, "R2 nothing sent", 32'(rx_cnt - base), 32'd0);
    tx_en_i = 0;
    repeat (2) @(negedge clk);
    chk(ready_o == 1'b1, "R2 still empty after disable", 32'(ready_o), 32'd1);

    // R3: ninth pair overwrites the eighth entry
    base = rx_cnt;
    for (int i = 0; i < 9; i++) load_word(32'h0100_0000 + 32'(i));
    tx_en_i = 1;
    wait_ready();
    repeat (4) @(negedge clk);
    chk(rx_cnt - base == 256, "R3 eight words sent", 32'(rx_cnt - base), 32'd256);
    chk(got_word(base + 224, 32) == exp_word(32'h0100_0008, 0, 0, 1, 0), "R3 last entry replaced",
        got_word(base + 224, 32), exp_word(32'h0100_0008, 0, 0, 1, 0));
    chk(got_word(base + 192, 32) == exp_word(32'h0100_0006, 0, 0, 1, 0), "R3 seventh kept",
        got_word(base + 192, 32), exp_word(32'h0100_0006, 0, 0, 1, 0));
    tx_en_i = 0;

    // R10: format change mid-word has no effect on it
    base = rx_cnt;
    load_word(32'h5A5A_0F0F);
    tx_en_i = 1;
    for (int i = 0; i < 5000 && rx_cnt - base < 5; i++) @(negedge clk);
    slow_rate_i = 1; short_word_i = 1;
    wait_ready();
    repeat (4) @(negedge clk);
    chk(rx_cnt - base == 32, "R10 length held", 32'(rx_cnt - base), 32'd32);
    check_word(base, 32, HI_DIV, exp_word(32'h5A5A_0F0F, 0, 0, 1, 0), "R10 word held");
    slow_rate_i = 0; short_word_i = 0; tx_en_i = 0;
    repeat (200) @(negedge clk);

    // R11: reset mid-word
    load_word(32'hFFFF_0000);
    load_word(32'h1111_2222);
    tx_en_i = 1;
    base = rx_cnt;
    for (int i = 0; i < 5000 && rx_cnt - base < 5; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk(!rail_a_o && !rail_b_o, "R11 rails low in reset", {30'd0, rail_a_o, rail_b_o}, 32'd0);
    chk(ready_o == 1'b1, "R11 ready in reset", 32'(ready_o), 32'd1);
    rst_ni = 1;
    base = rx_cnt;
    repeat (800) @(negedge clk);
    chk(rx_cnt == base, "R11 buffer cleared", 32'(rx_cnt - base), 32'd0);
    tx_en_i = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule